// File: doc/BRIEF.md
# Processor Interrupt Recognition Unit

This unit sits ahead of a processor core's sequencer and decides, at each point where execution may be suspended, whether an external interrupt is taken. It watches two request lines. One is a maskable request that arrives asynchronously to the core clock. The other is a non-maskable request. The unit also receives the core's interrupt-enable flag, the current operating mode, a per-instruction boundary strobe, a per-iteration strobe from repeated string operations, and a return-from-interrupt strobe.

A non-maskable request always resolves to vector 2 and needs no bus traffic. A maskable request runs two consecutive interrupt-acknowledge bus cycles. The vector byte returned on the second of those cycles is captured and presented to the core. Requests too brief to be genuine are filtered out. The maskable line has to have been seen high for a minimum number of synchronised clock samples when the boundary arrives.

Top module: `int_recog`

## Requirements
- R1: A taken non-maskable interrupt reports `take=1`, `take_nmi=1`, `vec_valid=1` and `vec=2` together, one clock after the boundary, and starts no acknowledge bus cycle.
- R2: After a non-maskable interrupt is taken, further non-maskable requests are not taken until `iret` has been pulsed.
- R3: On a taken non-maskable interrupt, `ie_clr` pulses if `real_mode` is 1. When `real_mode` is 0, `ie_clr` follows `gate_clr_ie`.
- R4: A maskable interrupt is taken only at a clock where `insn_bnd` or `rep_bnd` is 1.
- R5: A maskable interrupt is taken only when `ie` is 1 at the boundary.
- R6: `mreq_async` passes through a two-flop synchroniser into a saturating counter, which is cleared while the synchronised level is low. A boundary driven at the k-th falling edge after `mreq_async` rises is accepted only if k >= 10, which means at least 8 synchronised high samples.
- R7: A taken maskable interrupt raises `ack_cyc` with `ack_second=0`. After `ack_done`, it raises `ack_cyc` with `ack_second=1`. After a second `ack_done`, it returns to idle.
- R8: The vector comes from `ack_data` on the second acknowledge cycle and appears with `vec_valid=1` one clock after that `ack_done`. The data on the first cycle is ignored.
- R9: `rep_bnd` counts as a boundary in the same way as `insn_bnd`.
- R10: When both requests are eligible at the same boundary, the non-maskable one is taken.
- R11: A rising edge on `nmi_req` is held pending until it is taken, even if the input falls. The maskable request is not held: if it drops before the boundary, nothing is taken.
- R12: After reset, all outputs are 0 and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mreq_async | input | 1 | Maskable request, asynchronous |
| nmi_req | input | 1 | Non-maskable request (rising edge latched) |
| ie | input | 1 | Maskable interrupt enable flag |
| real_mode | input | 1 | 1 = real mode, 0 = protected mode |
| gate_clr_ie | input | 1 | Protected-mode gate type: clear enable on NMI |
| insn_bnd | input | 1 | Instruction boundary strobe |
| rep_bnd | input | 1 | Repeated-string iteration boundary strobe |
| iret | input | 1 | Return-from-interrupt strobe |
| ack_done | input | 1 | Current acknowledge bus cycle has finished |
| ack_data | input | VW | Byte returned on the acknowledge bus |
| take | output | 1 | Interrupt taken (one-clock pulse) |
| take_nmi | output | 1 | Taken interrupt is non-maskable |
| ie_clr | output | 1 | Core should clear its enable flag |
| ack_cyc | output | 1 | Acknowledge bus cycle requested |
| ack_second | output | 1 | Requested cycle is the second of the pair |
| vec_valid | output | 1 | `vec` holds the vector for the taken interrupt |
| vec | output | VW | Vector number |

## Verification
The hardest case to reach from the ports is the exact edge of the glitch filter. Synchroniser latency and counter latency add up, so a boundary one clock too early must be rejected and the next one accepted. The stimulus raises the request, strobes a boundary at the last rejected edge, and follows at once with a second boundary on the first accepted edge. It also exercises non-maskable nesting: a second edge arrives while the first is still in service, is held across `iret`, and is then taken at a later boundary after its input has already fallen.

// File: rtl/int_recog.sv
module int_recog #(
  parameter int HOLD    = 8,
  parameter int VW      = 8,
  parameter int NMI_VEC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mreq_async,
  input  logic          nmi_req,
  input  logic          ie,
  input  logic          real_mode,
  input  logic          gate_clr_ie,
  input  logic          insn_bnd,
  input  logic          rep_bnd,
  input  logic          iret,
  input  logic          ack_done,
  input  logic [VW-1:0] ack_data,
  output logic          take,
  output logic          take_nmi,
  output logic          ie_clr,
  output logic          ack_cyc,
  output logic          ack_second,
  output logic          vec_valid,
  output logic [VW-1:0] vec
);
  localparam int CW = $clog2(HOLD + 1);

  typedef enum logic [1:0] {IDLE, ACK1, ACK2} ack_t;
  ack_t st;

  logic          s1, s2, nmi_d, nmi_pend, nmi_act;
  logic [CW-1:0] cnt;

  wire bnd    = insn_bnd | rep_bnd;
  wire busy   = st != IDLE;
  wire go_nmi = bnd & nmi_pend & ~nmi_act & ~busy;
  wire go_int = bnd & ~go_nmi & ~busy & ie & (cnt >= CW'(HOLD));
  wire got_v  = (st == ACK2) & ack_done;

  assign ack_cyc    = busy;
  assign ack_second = st == ACK2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; cnt <= '0;
    end else begin
      s1 <= mreq_async;
      s2 <= s1;
      if (!s2) cnt <= '0;
      else if (cnt < CW'(HOLD)) cnt <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      nmi_d <= 1'b0; nmi_pend <= 1'b0; nmi_act <= 1'b0;
    end else begin
      nmi_d    <= nmi_req;
      nmi_pend <= (nmi_pend & ~go_nmi) | (nmi_req & ~nmi_d);
      if (go_nmi) nmi_act <= 1'b1;
      else if (iret) nmi_act <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= IDLE;
    else case (st)
      IDLE:    if (go_int) st <= ACK1;
      ACK1:    if (ack_done) st <= ACK2;
      ACK2:    if (ack_done) st <= IDLE;
      default: st <= IDLE;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      take <= 1'b0; take_nmi <= 1'b0; ie_clr <= 1'b0;
      vec_valid <= 1'b0; vec <= '0;
    end else begin
      take      <= go_nmi | go_int;
      take_nmi  <= go_nmi;
      ie_clr    <= go_nmi & (real_mode | gate_clr_ie);
      vec_valid <= go_nmi | got_v;
      if (go_nmi) vec <= VW'(NMI_VEC);
      else if (got_v) vec <= ack_data;
    end
endmodule

// File: rtl/int_recog_chk.sv
module int_recog_chk #(
  parameter int VW      = 8,
  parameter int NMI_VEC = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ie,
  input logic          real_mode,
  input logic          insn_bnd,
  input logic          rep_bnd,
  input logic          iret,
  input logic          ack_done,
  input logic [VW-1:0] ack_data,
  input logic          take,
  input logic          take_nmi,
  input logic          ie_clr,
  input logic          ack_cyc,
  input logic          ack_second,
  input logic          vec_valid,
  input logic [VW-1:0] vec
);
  logic in_nmi;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) in_nmi <= 1'b0;
    else if (iret) in_nmi <= 1'b0;
    else if (take && take_nmi) in_nmi <= 1'b1;

  AST_NMI_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |-> take && vec_valid && vec == VW'(NMI_VEC) && !ack_cyc); // R1
  AST_NMI_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    take && take_nmi |-> !in_nmi); // R2
  AST_REAL_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    take && take_nmi && $past(real_mode) |-> ie_clr); // R3
  AST_CLR_ONLY_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    ie_clr |-> take_nmi); // R3
  AST_MASK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    take && !take_nmi |-> $past(insn_bnd || rep_bnd)); // R4
  AST_MASK_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    take && !take_nmi |-> $past(ie)); // R5
  AST_SECOND_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_second) |-> $past(ack_cyc && !ack_second && ack_done)); // R7
  AST_VEC_FROM_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !take |-> $past(ack_second && ack_done) && vec == $past(ack_data)); // R8
endmodule

bind int_recog int_recog_chk #(.VW(VW), .NMI_VEC(NMI_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ie(ie), .real_mode(real_mode),
  .insn_bnd(insn_bnd), .rep_bnd(rep_bnd), .iret(iret),
  .ack_done(ack_done), .ack_data(ack_data), .take(take),
  .take_nmi(take_nmi), .ie_clr(ie_clr), .ack_cyc(ack_cyc),
  .ack_second(ack_second), .vec_valid(vec_valid), .vec(vec));

// File: tb/int_recog_tb.sv
module int_recog_tb;
  logic clk = 0, rst_n = 0;
  logic mreq_async = 0, nmi_req = 0, ie = 0, real_mode = 1, gate_clr_ie = 0;
  logic insn_bnd = 0, rep_bnd = 0, iret = 0, ack_done = 0;
  logic [7:0] ack_data = 0;
  logic take, take_nmi, ie_clr, ack_cyc, ack_second, vec_valid;
  logic [7:0] vec;

  int n_chk = 0, n_err = 0;

  typedef struct { bit nmi; logic [7:0] v; string req; } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  int_recog u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input bit nmi, input logic [7:0] v, input string req);
    item_t it;
    it.nmi = nmi; it.v = v; it.req = req;
    sb.push_back(it);
  endtask

  always @(negedge clk) if (rst_n && vec_valid) begin
    if (sb.size() == 0) chk(0, "R1/R8 unexpected vector", vec, 0);
    else begin
      item_t it;
      it = sb.pop_front();
      chk(vec == it.v && take_nmi == it.nmi, it.req, vec, it.v);
    end
  end

  task automatic bnd(input bit rep, output bit tk, output bit tn, output bit clr);
    if (rep) rep_bnd = 1; else insn_bnd = 1;
    @(negedge clk);
    insn_bnd = 0; rep_bnd = 0;
    tk = take; tn = take_nmi; clr = ie_clr;
  endtask

  task automatic pulse_nmi();
    nmi_req = 1; @(negedge clk); nmi_req = 0; @(negedge clk);
  endtask

  task automatic pulse_iret();
    iret = 1; @(negedge clk); iret = 0; @(negedge clk);
  endtask

  task automatic run_ack(input logic [7:0] d1, input logic [7:0] d2, input string req);
    chk(ack_cyc && !ack_second, req, {ack_cyc, ack_second}, 2'b10);
    ack_done = 1; ack_data = d1; @(negedge clk);
    ack_done = 0;
    chk(ack_cyc && ack_second, req, {ack_cyc, ack_second}, 2'b11);
    ack_done = 1; ack_data = d2; @(negedge clk);
    ack_done = 0;
    @(negedge clk);
    chk(!ack_cyc, req, ack_cyc, 0);
  endtask

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    bit tk, tn, clr;
    repeat (3) @(negedge clk);
    chk({take, take_nmi, ie_clr, ack_cyc, ack_second, vec_valid, vec} == 0, "R12 reset", vec, 0);
    rst_n = 1;
    @(negedge clk);

    // R1/R3 real mode NMI
    pulse_nmi();
    push(1, 8'd2, "R1 nmi vector");
    bnd(0, tk, tn, clr);
    chk(tk && tn && clr, "R1/R3 nmi take real", {tk, tn, clr}, 3'b111);
    chk(!ack_cyc, "R1 no ack on nmi", ack_cyc, 0);

    // R2/R11 nested NMI held until iret, survives input drop
    pulse_nmi();
    bnd(0, tk, tn, clr);
    chk(!tk, "R2 nmi nested blocked", tk, 0);
    pulse_iret();
    real_mode = 0; gate_clr_ie = 0;
    push(1, 8'd2, "R11 latched nmi vector");
    bnd(0, tk, tn, clr);
    chk(tk && tn && !clr, "R11/R3 latched nmi protected no clear", {tk, tn, clr}, 3'b110);
    pulse_iret();
    pulse_nmi();
    gate_clr_ie = 1;
    push(1, 8'd2, "R3 nmi vector gate");
    bnd(0, tk, tn, clr);
    chk(tk && clr, "R3 protected gate clears", {tk, clr}, 2'b11);
    pulse_iret();
    real_mode = 1;

    // R6 glitch filter edge, R8 vector from second cycle
    ie = 1;
    mreq_async = 1;
    repeat (9) @(negedge clk);
    bnd(0, tk, tn, clr);
    chk(!tk, "R6 too short rejected", tk, 0);
    bnd(0, tk, tn, clr);
    chk(tk && !tn, "R6 eight samples accepted", {tk, tn}, 2'b10);
    push(0, 8'h41, "R8 vector from second ack");
    run_ack(8'h99, 8'h41, "R7 ack sequence");

    // R4 no boundary: nothing taken
    repeat (20) begin
      @(negedge clk);
      chk(!take && !ack_cyc, "R4 no boundary no take", take, 0);
    end

    // R5 enable off
    ie = 0;
    bnd(0, tk, tn, clr);
    chk(!tk, "R5 disabled ignored", tk, 0);
    @(negedge clk);
    chk(!ack_cyc, "R5 no ack when disabled", ack_cyc, 0);
    ie = 1;

    // R9 repeat-string boundary
    bnd(1, tk, tn, clr);
    chk(tk && !tn, "R9 rep boundary taken", {tk, tn}, 2'b10);
    push(0, 8'h7e, "R9 vector");
    run_ack(8'h00, 8'h7e, "R9 ack sequence");

    // R10 priority
    pulse_nmi();
    push(1, 8'd2, "R10 nmi wins vector");
    bnd(0, tk, tn, clr);
    chk(tk && tn, "R10 nmi priority", {tk, tn}, 2'b11);
    pulse_iret();

    // R11 maskable not latched
    mreq_async = 0;
    repeat (4) @(negedge clk);
    bnd(0, tk, tn, clr);
    chk(!tk, "R11 dropped maskable not taken", tk, 0);
    @(negedge clk);
    chk(!ack_cyc, "R11 no ack after drop", ack_cyc, 0);

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R8 scoreboard drained", sb.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule